// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor with Target Cache

This block predicts, during instruction fetch, whether the branch at the current fetch address will be taken and where it will go. A table of 2-bit saturating counters is selected by low address bits and supplies the direction. A direct-mapped target cache holds, for each slot, a valid flag, an address tag and the last taken target. When the cache hits and the counter leans toward taken, fetch can be steered to the cached target in the same cycle. Otherwise the next address is the fetch address plus one instruction word.

When a branch resolves, the execute stage presents the branch address, the real outcome, the real target and a strobe on the resolve port. In that same cycle the block reports whether the prediction it would have made for that branch was wrong. It then trains the counter and, for a taken branch, fills or refreshes the cache slot. The pipeline uses the mispredict output to flush and refetch.

Top module: `bp_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weak not-taken) and every cache slot is invalid, so a fetch at any address gives hit 0, taken 0 and target = address + 4.
- R2: With default parameters the slot index is address bits [7:2] and the tag is bits [31:8]. A fetch hits only when the slot is valid and its stored tag equals the fetch tag. Addresses that share an index share one counter.
- R3: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The predicted direction is bit 1. A resolved taken branch steps the counter up by one, saturating at 11. A resolved not-taken branch steps it down by one, saturating at 00.
- R4: From a strong state, the predicted direction changes only after two consecutive resolves against it.
- R5: A resolved taken branch writes its tag and actual target into its slot and marks it valid, overwriting any earlier contents. A fetch of that address in the following cycle hits and returns the new target.
- R6: A resolved not-taken branch leaves the target cache unchanged.
- R7: The predicted target is the cached target when the fetch hits and bit 1 of the counter is 1. Otherwise it is the fetch address + 4.
- R8: When a fetch and a resolve address the same slot in the same cycle, the fetch outputs reflect the contents from before that resolve. The update is visible in the next cycle.
- R9: The mispredict output is combinational in the resolve cycle. It is 1 when the actual direction differs from the counter's bit 1, or when the branch is taken and the cache misses or holds a different target.
- R10: While the resolve strobe is 0, mispredict is 0 and no counter or cache slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Fetch address being looked up |
| pred_hit | output | 1 | Target cache hit for fetch_pc |
| pred_taken | output | 1 | Predicted direction (counter bit 1) |
| pred_target | output | 32 | Predicted next fetch address |
| resolve_valid | input | 1 | Strobe: a branch has resolved this cycle |
| resolve_pc | input | 32 | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch |
| resolve_target | input | 32 | Actual target of the resolved branch |
| resolve_mispredict | output | 1 | The prediction for the resolved branch was wrong |

## Verification
The fetch outputs and the mispredict flag are combinational, so they are due in the same cycle their inputs are applied. Training from a resolve becomes visible one clock edge later. The bench drives inputs just after the falling edge and compares all four outputs against its behavioural model shortly before the next rising edge. The model is advanced only after that edge, which matches the one-cycle write latency and the old-contents rule when a read and a write meet on the same slot. Directed phases cover saturation, hysteresis, aliasing, overwrite and idle strobes, and a long random phase over a small address pool then forces frequent slot conflicts.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [1:0] {
      CNT_STRONG_NT = 2'b00,
      CNT_WEAK_NT   = 2'b01,
      CNT_WEAK_T    = 2'b10,
      CNT_STRONG_T  = 2'b11
   } bp_cnt_e;

   localparam logic [1:0] CNT_RESET = CNT_WEAK_NT;

   // one training step of a saturating counter
   function automatic logic [1:0] bp_cnt_step(input logic [1:0] cur, input logic taken);
      logic [1:0] nxt;
      nxt = cur;
      if (taken) begin
         if (cur != CNT_STRONG_T) nxt = cur + 2'd1;
      end else begin
         if (cur != CNT_STRONG_NT) nxt = cur - 2'd1;
      end
      return nxt;
   endfunction

   function automatic logic bp_cnt_dir(input logic [1:0] cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
   import bp_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_a,
   output logic [1:0]       rd_cnt_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic [1:0]       rd_cnt_b,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int ENTRIES = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("bp_dir_table: IDX_W out of range");
      end
   endgenerate

   logic [ENTRIES-1:0][1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CNT_RESET;
      end else if (wr_en) begin
         cnt_q[wr_idx] <= bp_cnt_step(cnt_q[wr_idx], wr_taken);
      end
   end

   assign rd_cnt_a = cnt_q[rd_idx_a];
   assign rd_cnt_b = cnt_q[rd_idx_b];

   // R3: saturation at both ends
   assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && cnt_q[wr_idx] == CNT_STRONG_T) |=> cnt_q[$past(wr_idx)] == CNT_STRONG_T);
   assert_sat_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && cnt_q[wr_idx] == CNT_STRONG_NT) |=> cnt_q[$past(wr_idx)] == CNT_STRONG_NT);
   // R4: a single step per resolve, so a strong state needs two resolves to flip
   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && cnt_q[wr_idx] != CNT_STRONG_T)
      |=> cnt_q[$past(wr_idx)] == 2'($past(cnt_q[wr_idx]) + 2'd1));
   // R10: idle strobe keeps every counter
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
   parameter int IDX_W      = 6,
   parameter int TAG_W      = 24,
   parameter int PC_W       = 32,
   parameter int ALIGN      = 2,
   parameter bit DROP_ALIGN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_a,
   input  logic [TAG_W-1:0] rd_tag_a,
   output logic             hit_a,
   output logic [PC_W-1:0]  tgt_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   input  logic [TAG_W-1:0] rd_tag_b,
   output logic             hit_b,
   output logic [PC_W-1:0]  tgt_b,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_tgt
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int STORE_W = DROP_ALIGN ? (PC_W - ALIGN) : PC_W;

   generate
      if (TAG_W < 1 || TAG_W > PC_W) begin : g_bad_tag
         $error("bp_target_cache: TAG_W out of range");
      end
      if (ALIGN < 1 || ALIGN >= PC_W) begin : g_bad_align
         $error("bp_target_cache: ALIGN out of range");
      end
   endgenerate

   logic [ENTRIES-1:0]              vld_q;
   logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
   logic [ENTRIES-1:0][STORE_W-1:0] tgt_q;
   logic [STORE_W-1:0]              wr_store;
   logic [PC_W-1:0]                 tgt_raw_a;
   logic [PC_W-1:0]                 tgt_raw_b;

   generate
      if (DROP_ALIGN) begin : g_packed_tgt
         assign wr_store  = wr_tgt[PC_W-1:ALIGN];
         assign tgt_raw_a = {tgt_q[rd_idx_a], {ALIGN{1'b0}}};
         assign tgt_raw_b = {tgt_q[rd_idx_b], {ALIGN{1'b0}}};
      end else begin : g_full_tgt
         assign wr_store  = wr_tgt;
         assign tgt_raw_a = tgt_q[rd_idx_a];
         assign tgt_raw_b = tgt_q[rd_idx_b];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_store;
      end
   end

   assign hit_a = vld_q[rd_idx_a] && (tag_q[rd_idx_a] == rd_tag_a);
   assign hit_b = vld_q[rd_idx_b] && (tag_q[rd_idx_b] == rd_tag_b);
   assign tgt_a = tgt_raw_a;
   assign tgt_b = tgt_raw_b;

   // R5: a write leaves the slot valid with the written tag
   assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag));
   // R6: without a write the valid flags do not move
   assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> vld_q == $past(vld_q));

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
   import bp_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int IDX_W      = 6,
   parameter int ALIGN      = 2,
   parameter bit DROP_ALIGN = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_target,
   input  logic            resolve_valid,
   input  logic [PC_W-1:0] resolve_pc,
   input  logic            resolve_taken,
   input  logic [PC_W-1:0] resolve_target,
   output logic            resolve_mispredict
);
   localparam int TAG_LO = IDX_W + ALIGN;
   localparam int TAG_W  = PC_W - TAG_LO;
   localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(1) << ALIGN;

   generate
      if (TAG_W < 1) begin : g_bad_split
         $error("bp_predictor: index and alignment leave no tag bits");
      end
   endgenerate

   logic [IDX_W-1:0] f_idx, r_idx;
   logic [TAG_W-1:0] f_tag, r_tag;
   logic [1:0]       f_cnt, r_cnt;
   logic             f_hit, r_hit;
   logic [PC_W-1:0]  f_tgt, r_tgt;
   logic             cache_wr;

   assign f_idx = fetch_pc[TAG_LO-1:ALIGN];
   assign f_tag = fetch_pc[PC_W-1:TAG_LO];
   assign r_idx = resolve_pc[TAG_LO-1:ALIGN];
   assign r_tag = resolve_pc[PC_W-1:TAG_LO];
   assign cache_wr = resolve_valid && resolve_taken;

   bp_dir_table #(.IDX_W(IDX_W)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx_a (f_idx),
      .rd_cnt_a (f_cnt),
      .rd_idx_b (r_idx),
      .rd_cnt_b (r_cnt),
      .wr_en    (resolve_valid),
      .wr_idx   (r_idx),
      .wr_taken (resolve_taken)
   );

   bp_target_cache #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .ALIGN(ALIGN), .DROP_ALIGN(DROP_ALIGN)
   ) u_btb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx_a (f_idx),
      .rd_tag_a (f_tag),
      .hit_a    (f_hit),
      .tgt_a    (f_tgt),
      .rd_idx_b (r_idx),
      .rd_tag_b (r_tag),
      .hit_b    (r_hit),
      .tgt_b    (r_tgt),
      .wr_en    (cache_wr),
      .wr_idx   (r_idx),
      .wr_tag   (r_tag),
      .wr_tgt   (resolve_target)
   );

   always_comb begin
      pred_hit    = f_hit;
      pred_taken  = bp_cnt_dir(f_cnt);
      pred_target = (f_hit && pred_taken) ? f_tgt : (fetch_pc + INSN_BYTES);
   end

   logic dir_wrong, tgt_wrong;
   always_comb begin
      dir_wrong = resolve_taken != bp_cnt_dir(r_cnt);
      tgt_wrong = resolve_taken && (!r_hit || (r_tgt != resolve_target));
      resolve_mispredict = resolve_valid && (dir_wrong || tgt_wrong);
   end

   // R5: a taken resolve makes the same address hit on the next fetch
   assert_hit_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cache_wr |=> (fetch_pc != $past(resolve_pc)) || pred_hit);
   // R10: no flag without a strobe
   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !resolve_valid |-> !resolve_mispredict);

endmodule

// File: tb/tb_bp_predictor.sv
module tb_bp_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_hit, pred_taken, resolve_mispredict;
   logic [31:0] pred_target;
   logic        resolve_valid = 1'b0;
   logic [31:0] resolve_pc = '0;
   logic        resolve_taken = 1'b0;
   logic [31:0] resolve_target = '0;

   always #4 clk = ~clk;   // 125 MHz

   bp_predictor dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
      .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
      .resolve_taken(resolve_taken), .resolve_target(resolve_target),
      .resolve_mispredict(resolve_mispredict)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int          m_cnt [64];
   bit          m_vld [64];
   logic [23:0] m_tag [64];
   logic [31:0] m_tgt [64];

   function automatic int ix(logic [31:0] pc);
      return int'(pc[7:2]);
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 64; i++) begin
         m_cnt[i] = 1; m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
      end
   endtask

   // one cycle: drive, compare before the rising edge, then train the model
   task automatic step(logic [31:0] fpc, bit rv, logic [31:0] rpc, bit rt,
                       logic [31:0] rtgt, string req);
      int fi, ri;
      bit e_hit, e_tk, r_hit, e_mis;
      logic [31:0] e_tgt;
      @(negedge clk);
      fetch_pc = fpc; resolve_valid = rv; resolve_pc = rpc;
      resolve_taken = rt; resolve_target = rtgt;
      #3;
      fi = ix(fpc);
      ri = ix(rpc);
      e_hit = m_vld[fi] && (m_tag[fi] == fpc[31:8]);
      e_tk  = m_cnt[fi] >= 2;
      e_tgt = (e_hit && e_tk) ? m_tgt[fi] : fpc + 32'd4;
      r_hit = m_vld[ri] && (m_tag[ri] == rpc[31:8]);
      e_mis = rv && ((rt != (m_cnt[ri] >= 2)) || (rt && !(r_hit && m_tgt[ri] == rtgt)));
      chk(req, "R2 pred_hit", 32'(pred_hit), 32'(e_hit));
      chk(req, "R3 pred_taken", 32'(pred_taken), 32'(e_tk));
      chk(req, "R7 pred_target", pred_target, e_tgt);
      chk(req, "R9 mispredict", 32'(resolve_mispredict), 32'(e_mis));
      @(posedge clk);
      if (rv) begin
         if (rt) begin
            if (m_cnt[ri] < 3) m_cnt[ri]++;
            m_vld[ri] = 1; m_tag[ri] = rpc[31:8]; m_tgt[ri] = rtgt;
         end else if (m_cnt[ri] > 0) begin
            m_cnt[ri]--;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      step(32'h0000_0100, 0, 32'h0, 0, 32'h0, "R1");
      step(32'hFFFF_FFFC, 0, 32'h0, 0, 32'h0, "R1");
      // R8 and R9: first taken resolve mispredicts, same-slot fetch sees old contents
      step(32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, "R8");
      // R5: fill visible the next cycle
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R5");
      // R2: alias with a different tag misses but shares the counter
      step(32'h2000_1000, 0, 32'h0, 0, 32'h0, "R2");
      // R3: climb to strong taken and saturate
      step(32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, "R3");
      step(32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, "R3");
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R3");
      // R4 and R6: one not-taken keeps taken, cache slot untouched
      step(32'h0000_1000, 1, 32'h0000_1000, 0, 32'h0000_2000, "R4");
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R6");
      step(32'h0000_1000, 1, 32'h0000_1000, 0, 32'h0000_2000, "R4");
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R4");
      // R3: fall to strong not-taken and saturate
      step(32'h0000_1000, 1, 32'h0000_1000, 0, 32'h0, "R3");
      step(32'h0000_1000, 1, 32'h0000_1000, 0, 32'h0, "R3");
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R3");
      // R5: overwrite with a new target, target mismatch counts as mispredict
      step(32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_3000, "R5");
      step(32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_3000, "R9");
      step(32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_4400, "R9");
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R5");
      // R10: idle strobe with busy resolve fields changes nothing
      step(32'h0000_1000, 0, 32'h0000_1000, 0, 32'h0, "R10");
      step(32'h0000_1000, 0, 32'h0000_1000, 0, 32'h0, "R10");
      step(32'h0000_1000, 0, 32'h0, 0, 32'h0, "R10");
      // R7: alias slot taken but missing target falls through to pc + 4
      step(32'h2000_1000, 0, 32'h0, 0, 32'h0, "R7");

      // random phase over a small pool, forcing slot conflicts
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] fp, rp, tg;
         fp = {6'((($urandom) % 3)), 18'd0, 6'($urandom % 4), 2'b00} ;
         rp = {6'((($urandom) % 3)), 18'd0, 6'($urandom % 4), 2'b00} ;
         tg = {16'h0, 14'($urandom % 4), 2'b00};
         if ($urandom % 4 == 0) fp = rp;
         step(fp, 1'($urandom % 3 != 0), rp, 1'($urandom % 2), tg, "R9");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule